// File: doc/BRIEF.md
# SPI-Addressed 8-Bit Port Expander

This block is an SPI mode 0 slave that puts an 8-bit general-purpose port behind a small register file with byte-wide registers. Several expanders can share one chip select. Each one reacts only to frames whose control byte carries its own 3-bit hardware address, and only while its address-compare enable is set. A frame has three parts, in this order: a control byte, a register address byte, and one or more data bytes. The control byte holds a fixed upper nibble, three address bits and a read/write flag.

The SPI pins are asynchronous to the block clock. They are synchronized and oversampled, so SCK must run well below the system clock. After each data byte the register pointer moves to the next register, which allows burst access, unless the sequential-disable bit holds it in place. The port appears as separate input, output and output-enable vectors, plus a pull-up enable vector for the pad ring. Interrupt detection belongs to a separate block. Here its registers are only stored and read back.

Top module: `spx_top`

## Requirements
- R1: After reset the direction register is 0xFF and every other writable register is 0x00, so gpio_oe = 0x00, gpio_out = 0x00 and pullup_en = 0x00.
- R2: The device accepts a frame only when control byte bits [7:4] equal 4'b0100. Bit 0 = 1 selects a read and 0 selects a write. Any other upper nibble makes the whole frame ignored: no write, and spi_miso_oe stays 0.
- R3: While configuration bit 3 (address-compare enable, register 0x05) is 1, control byte bits [3:1] must equal hw_addr. A mismatching frame is ignored.
- R4: While configuration bit 3 is 0, only control address 3'b000 is accepted, whatever the hw_addr straps are. The reset value of bit 3 is 0.
- R5: While configuration bit 5 is 0, the register pointer advances by one after every data byte, read or write, and wraps from 0x0A to 0x00.
- R6: While configuration bit 5 is 1, the pointer stays put, so every byte of a burst reads or writes the same register. The pointer advance after a byte uses the configuration value from before that byte's write.
- R7: gpio_oe[i] is the inverse of direction bit i (register 0x00, where 1 means input), and gpio_out equals the output latch (register 0x0A).
- R8: A read of register 0x09 returns the synchronized gpio_in XOR the input-polarity register 0x01. A read of 0x0A returns the latch contents, not the pins.
- R9: Registers 0x07, 0x08 and any address above 0x0A read as 0x00 and ignore writes. Register 0x09 also ignores writes.
- R10: If chip select rises partway through a byte, that byte is discarded and no partial write is committed. The next frame starts cleanly.
- R11: spi_miso_oe is 0 while chip select is high and throughout write frames. It is 1 in the data phase of an accepted read frame.
- R12: pullup_en equals the pull-up register 0x06.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, must run at least 8x faster than SCK |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sck | input | 1 | SPI clock, mode 0 |
| spi_cs_n | input | 1 | Shared chip select, active low |
| spi_mosi | input | 1 | Serial data into the block, MSB first |
| spi_miso | output | 1 | Serial read data, MSB first |
| spi_miso_oe | output | 1 | Drive enable for spi_miso |
| hw_addr | input | 3 | Hardware address straps |
| gpio_in | input | 8 | Pad input levels |
| gpio_out | output | 8 | Pad output values (output latch) |
| gpio_oe | output | 8 | Pad drive enables, 1 = drive |
| pullup_en | output | 8 | Pad pull-up enables |

## Verification
Two functions can land in the same cycle: committing a data byte to the configuration register, and deciding where the pointer goes after that byte. The bench provokes this with a three-byte burst that starts at the configuration register and sets the sequential-disable bit in its first byte. The second byte must then land in the pull-up register under the old mode, and the third byte must land there again under the new mode. The pull-up output and a read-back of the configuration register judge the result. Read data is compared by a scoreboard against bytes that the driver queued from the requirements.

// File: rtl/spx_pkg.sv
package spx_pkg;
    localparam int BYTE_W = 8;

    localparam logic [7:0] ADR_DIR  = 8'h00;
    localparam logic [7:0] ADR_IPOL = 8'h01;
    localparam logic [7:0] ADR_IEN  = 8'h02;
    localparam logic [7:0] ADR_DCMP = 8'h03;
    localparam logic [7:0] ADR_ICTL = 8'h04;
    localparam logic [7:0] ADR_CFG  = 8'h05;
    localparam logic [7:0] ADR_PU   = 8'h06;
    localparam logic [7:0] ADR_PORT = 8'h09;
    localparam logic [7:0] ADR_LAT  = 8'h0A;

    localparam int CFG_SEQDIS = 5;
    localparam int CFG_HAEN   = 3;
    localparam logic [3:0] CTL_TAG = 4'b0100;

    typedef enum logic [1:0] {F_CTRL, F_ADDR, F_DATA, F_SKIP} frame_t;

    typedef struct packed {
        logic [7:0] dir;
        logic [7:0] ipol;
        logic [7:0] ien;
        logic [7:0] dcmp;
        logic [7:0] ictl;
        logic [7:0] cfg;
        logic [7:0] pu;
        logic [7:0] lat;
    } regbank_t;
endpackage

// File: rtl/spx_sync.sv
module spx_sync #(
    parameter int W = 1,
    parameter int STAGES = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [STAGES-1:0][W-1:0] pipe_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < STAGES; s++) pipe_q[s] <= RST_VAL;
        end else begin
            pipe_q[0] <= d;
            for (int s = 1; s < STAGES; s++) pipe_q[s] <= pipe_q[s-1];
        end
    end

    assign q = pipe_q[STAGES-1];
endmodule

// File: rtl/spx_link.sv
module spx_link
    import spx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sck_s,
    input  logic              cs_s,
    input  logic              mosi_s,
    input  logic              tx_load,
    input  logic [BYTE_W-1:0] tx_byte,
    output logic              byte_vld,
    output logic [BYTE_W-1:0] rx_byte,
    output logic              miso_bit
);
    localparam int CNT_W = $clog2(BYTE_W);

    typedef struct packed {
        logic              sck;
        logic [CNT_W-1:0]  cnt;
        logic [BYTE_W-1:0] rx;
        logic [BYTE_W-1:0] tx;
        logic              vld;
    } link_t;

    link_t q, d;
    logic rise, fall;

    always_comb begin
        d     = q;
        d.vld = 1'b0;
        d.sck = sck_s;
        rise  = sck_s & ~q.sck;
        fall  = ~sck_s & q.sck;
        if (cs_s) begin
            d.cnt = '0;
        end else begin
            if (rise) begin
                d.rx  = {q.rx[BYTE_W-2:0], mosi_s};
                d.cnt = q.cnt + 1'b1;
                if (q.cnt == CNT_W'(BYTE_W-1)) d.vld = 1'b1;
            end
            if (fall && q.cnt != '0) d.tx = {q.tx[BYTE_W-2:0], 1'b0};
        end
        if (tx_load) d.tx = tx_byte;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign byte_vld = q.vld;
    assign rx_byte  = q.rx;
    assign miso_bit = q.tx[BYTE_W-1];

    AST_ABORT_CLEARS_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        cs_s |=> (q.cnt == '0)); // R10
endmodule

// File: rtl/spx_regs.sv
module spx_regs
    import spx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_s,
    input  logic              byte_vld,
    input  logic [BYTE_W-1:0] rx_byte,
    input  logic [2:0]        strap,
    input  logic [BYTE_W-1:0] pins_s,
    output logic              tx_load,
    output logic [BYTE_W-1:0] tx_byte,
    output logic              miso_oe,
    output logic [BYTE_W-1:0] dir,
    output logic [BYTE_W-1:0] lat,
    output logic [BYTE_W-1:0] pu
);
    typedef struct packed {
        frame_t            st;
        logic              rd;
        logic [7:0]        ptr;
        regbank_t          rb;
        logic              ld;
        logic [BYTE_W-1:0] txb;
        logic              oe;
    } regs_t;

    regs_t q, d;
    logic       ctl_ok;
    logic [2:0] my_addr;
    logic [7:0] nxt_ptr;

    function automatic logic [7:0] reg_read(input logic [7:0] a, input regbank_t rb,
                                            input logic [7:0] pins);
        case (a)
            ADR_DIR:  return rb.dir;
            ADR_IPOL: return rb.ipol;
            ADR_IEN:  return rb.ien;
            ADR_DCMP: return rb.dcmp;
            ADR_ICTL: return rb.ictl;
            ADR_CFG:  return rb.cfg;
            ADR_PU:   return rb.pu;
            ADR_PORT: return pins ^ rb.ipol;
            ADR_LAT:  return rb.lat;
            default:  return 8'h00;
        endcase
    endfunction

    always_comb begin
        d       = q;
        d.ld    = 1'b0;
        my_addr = q.rb.cfg[CFG_HAEN] ? strap : 3'b000;
        ctl_ok  = (rx_byte[7:4] == CTL_TAG) && (rx_byte[3:1] == my_addr);
        nxt_ptr = q.rb.cfg[CFG_SEQDIS] ? q.ptr :
                  (q.ptr == ADR_LAT) ? 8'h00 : q.ptr + 8'h01;
        if (cs_s) begin
            d.st = F_CTRL;
            d.oe = 1'b0;
        end else if (byte_vld) begin
            case (q.st)
                F_CTRL: begin
                    d.st = ctl_ok ? F_ADDR : F_SKIP;
                    d.rd = rx_byte[0];
                end
                F_ADDR: begin
                    d.ptr = rx_byte;
                    d.st  = F_DATA;
                    if (q.rd) begin
                        d.ld  = 1'b1;
                        d.txb = reg_read(rx_byte, q.rb, pins_s);
                        d.oe  = 1'b1;
                    end
                end
                F_DATA: begin
                    d.ptr = nxt_ptr;
                    if (q.rd) begin
                        d.ld  = 1'b1;
                        d.txb = reg_read(nxt_ptr, q.rb, pins_s);
                    end else begin
                        case (q.ptr)
                            ADR_DIR:  d.rb.dir  = rx_byte;
                            ADR_IPOL: d.rb.ipol = rx_byte;
                            ADR_IEN:  d.rb.ien  = rx_byte;
                            ADR_DCMP: d.rb.dcmp = rx_byte;
                            ADR_ICTL: d.rb.ictl = rx_byte;
                            ADR_CFG:  d.rb.cfg  = rx_byte;
                            ADR_PU:   d.rb.pu   = rx_byte;
                            ADR_LAT:  d.rb.lat  = rx_byte;
                            default:  ;
                        endcase
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q        <= '0;
            q.st     <= F_CTRL;
            q.rb.dir <= '1;
        end else begin
            q <= d;
        end
    end

    assign tx_load = q.ld;
    assign tx_byte = q.txb;
    assign miso_oe = q.oe;
    assign dir     = q.rb.dir;
    assign lat     = q.rb.lat;
    assign pu      = q.rb.pu;

    AST_QUIET_DESELECTED: assert property (@(posedge clk) disable iff (!rst_n)
        cs_s |=> !q.oe); // R11
    AST_QUIET_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_s && q.st == F_DATA && !q.rd) |=> !q.oe); // R11
    AST_HOLD_NO_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
        !byte_vld |=> $stable(q.rb)); // R10
    AST_SKIP_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == F_SKIP) |=> $stable(q.rb)); // R3
    AST_SEQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_vld && !cs_s && q.st == F_DATA && q.rb.cfg[CFG_SEQDIS]) |=> $stable(q.ptr)); // R6
    AST_PTR_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_vld && !cs_s && q.st == F_DATA && !q.rb.cfg[CFG_SEQDIS] && q.ptr == ADR_LAT)
        |=> (q.ptr == 8'h00)); // R5
endmodule

// File: rtl/spx_top.sv
module spx_top #(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       spi_sck,
    input  logic       spi_cs_n,
    input  logic       spi_mosi,
    output logic       spi_miso,
    output logic       spi_miso_oe,
    input  logic [2:0] hw_addr,
    input  logic [7:0] gpio_in,
    output logic [7:0] gpio_out,
    output logic [7:0] gpio_oe,
    output logic [7:0] pullup_en
);
    import spx_pkg::*;

    logic [2:0]        spi_s;
    logic [BYTE_W-1:0] pins_s;
    logic              byte_vld, tx_load, miso_bit, oe;
    logic [BYTE_W-1:0] rx_byte, tx_byte, dir;

    spx_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b010)) u_spi_sync (
        .clk(clk), .rst_n(rst_n),
        .d({spi_sck, spi_cs_n, spi_mosi}), .q(spi_s)
    );

    spx_sync #(.W(BYTE_W), .STAGES(SYNC_STAGES), .RST_VAL('0)) u_pin_sync (
        .clk(clk), .rst_n(rst_n), .d(gpio_in), .q(pins_s)
    );

    spx_link u_link (
        .clk(clk), .rst_n(rst_n),
        .sck_s(spi_s[2]), .cs_s(spi_s[1]), .mosi_s(spi_s[0]),
        .tx_load(tx_load), .tx_byte(tx_byte),
        .byte_vld(byte_vld), .rx_byte(rx_byte), .miso_bit(miso_bit)
    );

    spx_regs u_regs (
        .clk(clk), .rst_n(rst_n), .cs_s(spi_s[1]),
        .byte_vld(byte_vld), .rx_byte(rx_byte), .strap(hw_addr), .pins_s(pins_s),
        .tx_load(tx_load), .tx_byte(tx_byte), .miso_oe(oe),
        .dir(dir), .lat(gpio_out), .pu(pullup_en)
    );

    assign gpio_oe     = ~dir;
    assign spi_miso_oe = oe;
    assign spi_miso    = oe & miso_bit;
endmodule

// File: tb/tb_spx_top.sv
module tb_spx_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       spi_sck = 1'b0, spi_cs_n = 1'b1, spi_mosi = 1'b0;
    logic       spi_miso, spi_miso_oe;
    logic [2:0] hw_addr = 3'b101;
    logic [7:0] gpio_in = 8'h3C;
    logic [7:0] gpio_out, gpio_oe, pullup_en;

    int n_chk = 0, n_fail = 0;
    bit done = 0;
    logic [7:0] dat [16];
    logic [7:0] exp_q [$];
    string      tag_q [$];

    always #5 clk = ~clk;

    spx_top dut (.*);

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
        end
    endtask

    task automatic half();
        repeat (10) @(negedge clk);
    endtask

    task automatic send_bits(input logic [7:0] b, input int nbits);
        for (int i = 7; i > 7 - nbits; i--) begin
            spi_mosi = b[i];
            half();
            spi_sck = 1'b1;
            half();
            spi_sck = 1'b0;
        end
    endtask

    task automatic cs_lo();
        spi_cs_n = 1'b0;
        half();
    endtask

    task automatic cs_hi();
        half();
        spi_cs_n = 1'b1;
        half(); half(); half();
    endtask

    task automatic frame(input logic [7:0] ctl, input logic [7:0] rg, input int n);
        cs_lo();
        send_bits(ctl, 8);
        send_bits(rg, 8);
        for (int i = 0; i < n; i++) send_bits(ctl[0] ? 8'h00 : dat[i], 8);
        cs_hi();
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] rg, input int n);
        frame({4'b0100, a, 1'b0}, rg, n);
    endtask

    task automatic rd(input logic [2:0] a, input logic [7:0] rg, input int n, input string tag);
        for (int i = 0; i < n; i++) begin
            exp_q.push_back(dat[i]);
            tag_q.push_back(tag);
        end
        frame({4'b0100, a, 1'b1}, rg, n);
    endtask

    task automatic probe(input logic [7:0] ctl, input logic [7:0] rg, output logic oe);
        cs_lo();
        send_bits(ctl, 8);
        send_bits(rg, 8);
        repeat (4) @(negedge clk);
        oe = spi_miso_oe;
        cs_hi();
    endtask

    // Monitor: assembles driven MISO bytes and scores them against the queue
    initial begin
        int nb = 0;
        logic [7:0] sh = 8'h00;
        forever begin
            @(posedge spi_sck or posedge spi_cs_n);
            if (spi_cs_n) nb = 0;
            else if (spi_miso_oe) begin
                sh = {sh[6:0], spi_miso};
                nb++;
                if (nb == 8) begin
                    nb = 0;
                    if (exp_q.size() == 0) begin
                        chk("R11 unexpected read byte", sh, 8'hxx);
                    end else begin
                        chk(tag_q.pop_front(), sh, exp_q.pop_front());
                    end
                end
            end
        end
    end

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic oe;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        // R1 reset values at the pins
        chk("R1 gpio_oe", gpio_oe, 8'h00);
        chk("R1 gpio_out", gpio_out, 8'h00);
        chk("R1 pullup_en", pullup_en, 8'h00);
        chk("R11 idle oe", {7'd0, spi_miso_oe}, 8'h00);

        // R1/R5: full burst from 0x00 with wrap past 0x0A
        dat = '{8'hFF, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00,
                8'h00, 8'h3C, 8'h00, 8'hFF, 8'h00, 8'h00, 8'h00, 8'h00};
        rd(3'b000, 8'h00, 13, "R1 R5 reset burst");

        // R7 direction and latch
        dat[0] = 8'hF0; wr(3'b000, 8'h00, 1);
        dat[0] = 8'h5A; wr(3'b000, 8'h0A, 1);
        chk("R7 gpio_oe", gpio_oe, 8'h0F);
        chk("R7 gpio_out", gpio_out, 8'h5A);

        // R5 write burst, R8 port and latch readback
        dat[0] = 8'h0F; dat[1] = 8'h11; dat[2] = 8'h22;
        wr(3'b000, 8'h01, 3);
        rd(3'b000, 8'h01, 3, "R5 burst readback");
        dat[0] = 8'h33; dat[1] = 8'h5A;
        rd(3'b000, 8'h09, 2, "R8 port xor polarity and latch");

        // R12 pull-up
        dat[0] = 8'hA5; wr(3'b000, 8'h06, 1);
        chk("R12 pullup_en", pullup_en, 8'hA5);

        // R9 reserved and read-only addresses
        dat[0] = 8'hFF; wr(3'b000, 8'h07, 1);
        dat[0] = 8'hFF; wr(3'b000, 8'h08, 1);
        dat[0] = 8'hFF; wr(3'b000, 8'h0C, 1);
        dat[0] = 8'h77; wr(3'b000, 8'h09, 1);
        dat[0] = 8'h00; dat[1] = 8'h00; dat[2] = 8'h33;
        rd(3'b000, 8'h07, 3, "R9 flag capture port");
        dat[0] = 8'h00; rd(3'b000, 8'h0C, 1, "R9 above top");
        chk("R9 latch untouched", gpio_out, 8'h5A);

        // R2 wrong control nibble
        dat[0] = 8'hFF; frame(8'h50, 8'h0A, 1);
        chk("R2 bad nibble write ignored", gpio_out, 8'h5A);
        probe(8'h51, 8'h0A, oe);
        chk("R2 bad nibble no drive", {7'd0, oe}, 8'h00);

        // R4 compare disabled: only address 000 is accepted
        dat[0] = 8'hEE; wr(3'b101, 8'h0A, 1);
        chk("R4 strap address refused", gpio_out, 8'h5A);

        // R3 enable address compare
        dat[0] = 8'h08; wr(3'b000, 8'h05, 1);
        dat[0] = 8'hEE; wr(3'b000, 8'h0A, 1);
        chk("R3 address 000 refused", gpio_out, 8'h5A);
        dat[0] = 8'h66; wr(3'b101, 8'h0A, 1);
        chk("R3 strap match", gpio_out, 8'h66);
        dat[0] = 8'h77; wr(3'b110, 8'h0A, 1);
        chk("R3 mismatch refused", gpio_out, 8'h66);
        probe(8'h41, 8'h0A, oe);
        chk("R3 mismatch no drive", {7'd0, oe}, 8'h00);

        // R6 mode change and pointer advance in the same byte
        dat[0] = 8'h28; dat[1] = 8'h77; dat[2] = 8'h99;
        wr(3'b101, 8'h05, 3);
        chk("R6 pull-up written twice", pullup_en, 8'h99);
        dat[0] = 8'h28; rd(3'b101, 8'h05, 1, "R6 cfg readback");
        dat[0] = 8'h11; dat[1] = 8'h22; dat[2] = 8'h33;
        wr(3'b101, 8'h0A, 3);
        chk("R6 latch holds last", gpio_out, 8'h33);
        chk("R6 direction untouched", gpio_oe, 8'h0F);
        dat[0] = 8'h33; dat[1] = 8'h33; dat[2] = 8'h33;
        rd(3'b101, 8'h0A, 3, "R6 repeated read");

        // R10 aborts mid-data and mid-control
        cs_lo(); send_bits(8'h4A, 8); send_bits(8'h0A, 8); send_bits(8'hFF, 4); cs_hi();
        chk("R10 partial byte dropped", gpio_out, 8'h33);
        cs_lo(); send_bits(8'h4A, 3); cs_hi();
        dat[0] = 8'h44; wr(3'b101, 8'h0A, 1);
        chk("R10 recovery", gpio_out, 8'h44);

        // R11 drive enable
        probe(8'h4A, 8'h0A, oe);
        chk("R11 write frame quiet", {7'd0, oe}, 8'h00);
        probe(8'h4B, 8'h0A, oe);
        chk("R11 read frame drives", {7'd0, oe}, 8'h01);
        chk("R11 quiet after deselect", {7'd0, spi_miso_oe}, 8'h00);

        chk("R11 all read bytes seen", 8'(exp_q.size()), 8'h00);
        finish_run();
    end
endmodule